// File: doc/BRIEF.md
# Serial EEPROM Command Front-End with Edge-Exact Cancel

This block is the command side of a small serially accessed EEPROM. While the chip select `spi_csb` is low, it takes one bit from `spi_si` on every rising edge of `spi_sck`. The first byte is the command. Memory commands then carry a 16-bit address, and write commands carry one data byte. All fields arrive most significant bit first. Read data and status leave on `spi_so` and change on falling `spi_sck` edges. The array itself sits outside the block and is reached through a one-cycle read strobe and a one-cycle write strobe.

Whether a frame is thrown away or carried out is settled at the moment `spi_csb` rises. The deciding quantity is the number of rising `spi_sck` edges seen up to that moment. Each command has its own commit point, and a frame that stops short of that point, or runs past it, is dropped. A committed write starts an internal busy period of `W_CYC` system clocks. During that period the status register reports a write in progress, and only status reads are served.

Top module: `spi_eeprom_front`

## Requirements
- R1: Command codes: 0x01 = status write, 0x02 = byte write, 0x03 = byte read, 0x04 = clear write enable, 0x05 = status read, 0x06 = set write enable. All fields are shifted in MSB first.
- R2: Byte read (0x03 followed by a 16-bit address): `mem_rd` pulses after the 24th rising edge, with `mem_addr` equal to the address. The returned byte then appears on `spi_so` MSB first, one bit per falling edge, with D7 valid after the 24th falling edge.
- R3: Status read (0x05): the eight bits after the command are {user[5:0], wel, wip}. Bit 0 is write-in-progress and bit 1 is the write-enable latch. Both are 0 after reset.
- R4: While `spi_csb` is high, `spi_so` is 0. A read or status read cut short leaves the status, and the array, unchanged.
- R5: Set and clear write enable take effect only if `spi_csb` rises after at least 8 rising edges. With fewer edges the frame is cancelled.
- R6: A byte write commits only if `spi_csb` rises after exactly 32 rising edges. Then `mem_wr` pulses once, with the frame's address and data. With 31 edges or fewer, or 33 edges or more, no write takes place.
- R7: A status write commits only if `spi_csb` rises after exactly 16 rising edges. It loads status bits 7..2 from data bits 7..2. With 15 edges or 17 edges the frame is cancelled.
- R8: A committed write sets write-in-progress for `W_CYC` clocks. Write-in-progress and the write-enable latch both clear when that period ends.
- R9: While write-in-progress is set, every command except status read is ignored. This includes write enable changes, writes and array reads.
- R10: An unrecognised command code causes no array access and no status change.
- R11: Byte write and status write are ignored while the write-enable latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_csb | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, sampled by `clk` |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| mem_rd | output | 1 | One-cycle array read strobe |
| mem_wr | output | 1 | One-cycle array write strobe |
| mem_addr | output | 16 | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid the cycle after `mem_rd` |

## Verification
The checks assume that `spi_csb`, `spi_sck` and `spi_si` are synchronous to `clk` and that each stays stable for several clocks. They also assume that `spi_csb` rises only while `spi_sck` is low, and that the array returns data one clock after the read strobe. The stimulus holds every serial level for six system clocks. It changes `spi_si` only while `spi_sck` is low, and raises `spi_csb` six clocks after the last falling edge. A cancel and a commit therefore never fall on the same edge.

// File: rtl/spi_eeprom_front.sv
module spi_eeprom_front #(
  parameter int W_CYC = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_csb,
  input  logic        spi_sck,
  input  logic        spi_si,
  output logic        spi_so,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  localparam int BW = $clog2(W_CYC + 1);
  localparam logic [7:0] OP_WRSR = 8'h01, OP_WRITE = 8'h02, OP_READ = 8'h03,
                         OP_WRDI = 8'h04, OP_RDSR  = 8'h05, OP_WREN  = 8'h06;

  logic          csb_q, sck_q, so_q, rd_pend, wel;
  logic [5:0]    cnt, user;
  logic [7:0]    sh, op, out_sh;
  logic [BW-1:0] busy_cnt;

  wire       wip      = busy_cnt != '0;
  wire       sck_rise = spi_sck & ~sck_q;
  wire       sck_fall = ~spi_sck & sck_q;
  wire       csb_rise = spi_csb & ~csb_q;
  wire [7:0] sh_nxt   = {sh[6:0], spi_si};
  wire [7:0] status   = {user, wel, wip};

  assign spi_so = so_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csb_q <= 1'b1; sck_q <= 1'b0; so_q <= 1'b0; rd_pend <= 1'b0; wel <= 1'b0;
      cnt <= '0; user <= '0; sh <= '0; op <= '0; out_sh <= '0; busy_cnt <= '0;
      mem_rd <= 1'b0; mem_wr <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      csb_q   <= spi_csb;
      sck_q   <= spi_sck;
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      rd_pend <= mem_rd;
      if (wip) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (busy_cnt == BW'(1)) wel <= 1'b0;
      end
      if (rd_pend) out_sh <= mem_rdata;
      if (spi_csb) begin
        cnt    <= '0;
        out_sh <= '0;
        so_q   <= 1'b0;
      end else begin
        if (sck_rise) begin
          sh <= sh_nxt;
          if (cnt != 6'd63) cnt <= cnt + 1'b1;
          if (cnt == 6'd7) op <= sh_nxt;
          if (cnt == 6'd7 && sh_nxt == OP_RDSR) out_sh <= status;
          if (cnt >= 6'd8 && cnt <= 6'd23) mem_addr <= {mem_addr[14:0], spi_si};
          if (cnt == 6'd23 && op == OP_READ && !wip) mem_rd <= 1'b1;
        end
        if (sck_fall) begin
          so_q   <= out_sh[7];
          out_sh <= {out_sh[6:0], 1'b0};
        end
      end
      if (csb_rise && !wip) begin
        case (op)
          OP_WREN: if (cnt >= 6'd8) wel <= 1'b1;
          OP_WRDI: if (cnt >= 6'd8) wel <= 1'b0;
          OP_WRITE:
            if (cnt == 6'd32 && wel) begin
              mem_wr    <= 1'b1;
              mem_wdata <= sh;
              busy_cnt  <= BW'(W_CYC);
            end
          OP_WRSR:
            if (cnt == 6'd16 && wel) begin
              user     <= sh[7:2];
              busy_cnt <= BW'(W_CYC);
            end
          default: ;
        endcase
      end
    end
  end
endmodule

module spi_eeprom_front_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_csb,
  input logic spi_so,
  input logic mem_rd,
  input logic mem_wr,
  input logic wel,
  input logic wip
);
  AST_WR_NEEDS_WEL:  assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> wel);                                   // R11
  AST_WR_NOT_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> !$past(wip));                           // R9
  AST_WR_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> $past(spi_csb) && !$past(spi_csb, 2));  // R6
  AST_SO_QUIET:      assert property (@(posedge clk) disable iff (!rst_n) $past(spi_csb) |-> !spi_so);                       // R4
  AST_WEL_CLEARS:    assert property (@(posedge clk) disable iff (!rst_n) $fell(wip) |-> !wel);                              // R8
  AST_RD_NOT_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) mem_rd |-> !wip && !$past(spi_csb));               // R2
  AST_ONE_STROBE:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0({mem_rd, mem_wr}));                        // R9
endmodule

bind spi_eeprom_front spi_eeprom_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_csb(spi_csb), .spi_so(spi_so),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .wel(wel), .wip(wip)
);

// File: tb/test_spi_eeprom_front.sv
module test_spi_eeprom_front;
  localparam int H = 6;
  localparam int W_CYC = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_csb = 1'b1, spi_sck = 1'b0, spi_si = 1'b0;
  logic spi_so, mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int vectors = 0, fails = 0, wr_count = 0;
  logic [7:0] mem [256];
  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  spi_eeprom_front #(.W_CYC(W_CYC)) i_spi_eeprom_front (
    .clk(clk), .rst_n(rst_n), .spi_csb(spi_csb), .spi_sck(spi_sck), .spi_si(spi_si),
    .spi_so(spi_so), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
  end

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic frame(input logic [39:0] v, input int n, input bit chk,
                       input logic [7:0] exp, input string tag);
    logic [7:0] rx = '0;
    if (chk) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    spi_csb = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      spi_si = v[39-i];
      repeat (H) @(negedge clk);
      rx = {rx[6:0], spi_so};
      spi_sck = 1'b1;
      repeat (H) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (H) @(negedge clk);
    spi_csb = 1'b1;
    repeat (2 * H) @(negedge clk);
    if (chk) got_q.push_back(rx);
  endtask

  task automatic rdsr(input logic [7:0] exp, input string tag);
    frame({8'h05, 32'h0}, 16, 1'b1, exp, tag);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (got_q.size() > 0) check({24'h0, got_q.pop_front()}, {24'h0, exp_q.pop_front()}, tag_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({31'h0, spi_so}, 32'h0, "R4 reset so");
    rdsr(8'h00, "R3 reset status");
    frame({8'h02, 16'h0040, 8'h77, 8'h0}, 32, 1'b0, 8'h0, "");
    check(wr_count, 0, "R11 write without wel");
    frame({8'h06, 32'h0}, 7, 1'b0, 8'h0, "");
    rdsr(8'h00, "R5 wren cut at 7 bits");
    frame({8'h06, 32'h0}, 8, 1'b0, 8'h0, "");
    rdsr(8'h02, "R5 wren sets wel");
    frame({8'h04, 32'h0}, 8, 1'b0, 8'h0, "");
    rdsr(8'h00, "R5 wrdi clears wel");
    frame({8'h06, 32'h0}, 8, 1'b0, 8'h0, "");
    frame({8'h02, 16'h0012, 8'hA5, 8'h0}, 31, 1'b0, 8'h0, "");
    check(wr_count, 0, "R6 write cut at D1");
    frame({8'h02, 16'h0012, 8'hA5, 8'h0}, 33, 1'b0, 8'h0, "");
    check(wr_count, 0, "R6 write with extra bit");
    frame({8'h09, 16'h0012, 8'hA5, 8'h0}, 32, 1'b0, 8'h0, "");
    check(wr_count, 0, "R10 unknown opcode no access");
    rdsr(8'h02, "R10 unknown opcode status kept");
    frame({8'h02, 16'h0012, 8'hA5, 8'h0}, 32, 1'b0, 8'h0, "");
    check(wr_count, 1, "R6 write commits");
    rdsr(8'h03, "R8 wip during write");
    frame({8'h02, 16'h0013, 8'h11, 8'h0}, 32, 1'b0, 8'h0, "");
    check(wr_count, 1, "R9 write ignored while busy");
    frame({8'h04, 32'h0}, 8, 1'b0, 8'h0, "");
    rdsr(8'h03, "R9 wrdi ignored while busy");
    repeat (W_CYC) @(negedge clk);
    rdsr(8'h00, "R8 wip and wel clear after cycle");
    check({24'h0, mem[8'h12]}, 32'hA5, "R6 array data");
    frame({8'h03, 16'h0012, 16'h0}, 32, 1'b1, 8'hA5, "R2 read written byte");
    frame({8'h03, 16'h0081, 16'h0}, 32, 1'b1, 8'h81, "R1 R2 read other address");
    frame({8'h03, 16'h0012, 16'h0}, 20, 1'b0, 8'h0, "");
    check({31'h0, spi_so}, 32'h0, "R4 so low after abort");
    rdsr(8'h00, "R4 read abort no change");
    frame({8'h06, 32'h0}, 8, 1'b0, 8'h0, "");
    frame({8'h01, 8'hFC, 24'h0}, 15, 1'b0, 8'h0, "");
    rdsr(8'h02, "R7 wrsr cut at 15 bits");
    frame({8'h01, 8'hFC, 24'h0}, 17, 1'b0, 8'h0, "");
    rdsr(8'h02, "R7 wrsr extra bit cancels");
    frame({8'h01, 8'hFC, 24'h0}, 16, 1'b0, 8'h0, "");
    rdsr(8'hFF, "R7 R8 wrsr busy status");
    repeat (W_CYC) @(negedge clk);
    rdsr(8'hFC, "R7 wrsr loaded user bits");
    frame({8'h01, 8'h00, 24'h0}, 16, 1'b0, 8'h0, "");
    rdsr(8'hFC, "R11 wrsr without wel");
    check(wr_count, 1, "R9 total writes");
    while (got_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule